// File: doc/BRIEF.md
# Priority Crossbar Switch

This block connects a set of processors to an equally sized set of memory modules through a full crossbar. Each processor raises a request together with the binary number of the module it wants. A combinational decoder turns that number into a one-hot column request. One fixed-priority chain per module column then picks the requester with the smallest processor index. The chosen crosspoints form an explicit enable matrix.

The same enable matrix steers data in both directions using AND masking and OR merging only. No tri-state or wired-OR structure appears anywhere. Write words travel from the granted processor to its module, and read words travel back from the module to that processor.

Every path is combinational from the current inputs. A copy of the enable matrix, registered on the clock, is also brought out for observation. Grants are not held from one cycle to the next. The parameters `N` (a power of two, 2 or more) and `W` set the port count and the word width.

Top module: `xbar_prio_top`

## Requirements
- R1: Processor i's target is the unsigned field `dst_addr[i*K +: K]`, with K = log2 N. A requesting processor can only be enabled at the column equal to that field.
- R2: The enable for row i, column j is bit `xp_en[i*N + j]`. A column never has more than one enable set. A processor whose `req` bit is low has no enable set, whatever its address field holds.
- R3: When several processors target the same column, the one with the smallest index receives that column.
- R4: Every column targeted by at least one requesting processor has exactly one enable set. `mem_act[j]` is high exactly when column j has an enable.
- R5: `mem_wdata[j*W +: W]` equals the write word of the processor enabled in column j, or zero when column j has no enable.
- R6: `proc_rdata[i*W +: W]` equals the read word of the module enabled in row i, or zero when processor i holds no grant.
- R7: `proc_gnt[i]` is the OR of row i's enables, and a row never has more than one enable.
- R8: `xp_en` follows the inputs in the same cycle. `xp_en_q` holds the value `xp_en` had at the previous rising clock edge, and is all zeros while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the observation register |
| rst_n | input | 1 | Active-low reset of the observation register |
| req | input | N | Per-processor request |
| dst_addr | input | N*K | Per-processor target module number |
| proc_wdata | input | N*W | Per-processor write word |
| mem_rdata | input | N*W | Per-module read word |
| mem_wdata | output | N*W | Per-module write word after steering |
| mem_act | output | N | Per-module column-granted flag |
| proc_rdata | output | N*W | Per-processor read word after steering |
| proc_gnt | output | N | Per-processor grant flag |
| xp_en | output | N*N | Crosspoint enable matrix, row-major |
| xp_en_q | output | N*N | Enable matrix registered on the clock |

## Verification
The assertions assume that `req` and `dst_addr` hold steady around each rising clock edge. They also assume that the address fields never decode outside the module range, which holds by construction when N is a power of two. The bench changes inputs only on falling edges and checks combinational outputs one nanosecond later. It checks the registered matrix just after the following rising edge, so every check sees settled values. The scenarios include idle inputs, disjoint targets, full contention, partial contention and addresses on non-requesting rows, all within these assumptions.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  // Flat position of crosspoint (row, col) in a row-major N*N matrix.
  function automatic int unsigned xp_index(int unsigned row, int unsigned col,
                                           int unsigned n);
    return row * n + col;
  endfunction

  // Base bit of lane 'lane' in a packed vector of 'width'-bit words.
  function automatic int unsigned lane_base(int unsigned lane, int unsigned width);
    return lane * width;
  endfunction
endpackage

// File: rtl/xbar_dest_dec.sv
module xbar_dest_dec #(
  parameter int N = 4,
  localparam int K = (N > 1) ? $clog2(N) : 1
) (
  input  logic         req,
  input  logic [K-1:0] addr,
  output logic [N-1:0] col_req
);
  for (genvar j = 0; j < N; j++) begin : g_col
    assign col_req[j] = req & (addr == K'(j));
  end
endmodule

// File: rtl/xbar_col_arb.sv
module xbar_col_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0] col_req,
  output logic [N-1:0] col_gnt
);
  // blocked[i] is high once any lower-indexed row has claimed the column
  logic [N:0] blocked;
  assign blocked[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign col_gnt[i]   = col_req[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | col_req[i];
  end
endmodule

// File: rtl/xbar_and_or.sv
module xbar_and_or
  import xbar_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic [N*N-1:0] en,
  input  logic [N*W-1:0] proc_wdata,
  input  logic [N*W-1:0] mem_rdata,
  output logic [N*W-1:0] mem_wdata,
  output logic [N*W-1:0] proc_rdata
);
  // Forward direction: each column ORs the masked write words of all rows
  always_comb begin
    mem_wdata = '0;
    for (int j = 0; j < N; j++) begin
      for (int i = 0; i < N; i++) begin
        mem_wdata[lane_base(j, W) +: W] = mem_wdata[lane_base(j, W) +: W]
          | (proc_wdata[lane_base(i, W) +: W] & {W{en[xp_index(i, j, N)]}});
      end
    end
  end

  // Return direction: each row ORs the masked read words of all columns
  always_comb begin
    proc_rdata = '0;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        proc_rdata[lane_base(i, W) +: W] = proc_rdata[lane_base(i, W) +: W]
          | (mem_rdata[lane_base(j, W) +: W] & {W{en[xp_index(i, j, N)]}});
      end
    end
  end
endmodule

// File: rtl/xbar_prio_top.sv
module xbar_prio_top
  import xbar_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 8,
  localparam int K = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   req,
  input  logic [N*K-1:0] dst_addr,
  input  logic [N*W-1:0] proc_wdata,
  input  logic [N*W-1:0] mem_rdata,
  output logic [N*W-1:0] mem_wdata,
  output logic [N-1:0]   mem_act,
  output logic [N*W-1:0] proc_rdata,
  output logic [N-1:0]   proc_gnt,
  output logic [N*N-1:0] xp_en,
  output logic [N*N-1:0] xp_en_q
);
  // row_req[i][j]: processor i asks for column j
  logic [N-1:0] row_req [N];
  // col_req[j][i]: transposed view handed to each column arbiter
  logic [N-1:0] col_req [N];
  logic [N-1:0] col_gnt [N];

  for (genvar i = 0; i < N; i++) begin : g_dec
    xbar_dest_dec #(.N(N)) u_dec (
      .req     (req[i]),
      .addr    (dst_addr[i*K +: K]),
      .col_req (row_req[i])
    );
  end

  for (genvar j = 0; j < N; j++) begin : g_arb
    for (genvar i = 0; i < N; i++) begin : g_tr
      assign col_req[j][i]              = row_req[i][j];
      assign xp_en[xp_index(i, j, N)]   = col_gnt[j][i];
    end
    xbar_col_arb #(.N(N)) u_arb (
      .col_req (col_req[j]),
      .col_gnt (col_gnt[j])
    );
    assign mem_act[j] = |col_gnt[j];
  end

  for (genvar i = 0; i < N; i++) begin : g_row
    assign proc_gnt[i] = |xp_en[i*N +: N];
  end

  xbar_and_or #(.N(N), .W(W)) u_path (
    .en         (xp_en),
    .proc_wdata (proc_wdata),
    .mem_rdata  (mem_rdata),
    .mem_wdata  (mem_wdata),
    .proc_rdata (proc_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xp_en_q <= '0;
    else        xp_en_q <= xp_en;
  end
endmodule

// File: rtl/xbar_prio_chk.sv
module xbar_prio_chk #(
  parameter int N = 4,
  parameter int W = 8,
  localparam int K = (N > 1) ? $clog2(N) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N-1:0]   req,
  input logic [N*K-1:0] dst_addr,
  input logic [N*W-1:0] proc_rdata,
  input logic [N-1:0]   proc_gnt,
  input logic [N-1:0]   mem_act,
  input logic [N*N-1:0] xp_en,
  input logic [N*N-1:0] xp_en_q
);
  logic [N-1:0] colv [N];
  logic [N-1:0] wanted;
  logic [N-1:0] lower_hit [N];
  logic         past_ok;

  always_comb begin
    wanted = '0;
    for (int j = 0; j < N; j++) begin
      for (int i = 0; i < N; i++) colv[j][i] = xp_en[i*N + j];
    end
    for (int i = 0; i < N; i++) begin
      if (req[i]) wanted[dst_addr[i*K +: K]] = 1'b1;
      lower_hit[i] = '0;
      for (int p = 0; p < i; p++)
        if (req[p]) lower_hit[i][dst_addr[p*K +: K]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  for (genvar j = 0; j < N; j++) begin : g_c
    assert_col_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(colv[j]));
    assert_col_served_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wanted[j] |-> ($countones(colv[j]) == 1 && mem_act[j]));
  end

  for (genvar i = 0; i < N; i++) begin : g_r
    assert_idle_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !req[i] |-> (xp_en[i*N +: N] == '0));
    assert_row_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
      proc_gnt[i] |-> xp_en[i*N + int'(dst_addr[i*K +: K])]);
    assert_row_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (proc_gnt[i] == |xp_en[i*N +: N]) && $onehot0(xp_en[i*N +: N]));
    assert_no_grant_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !proc_gnt[i] |-> (proc_rdata[i*W +: W] == '0));
    for (genvar j = 0; j < N; j++) begin : g_x
      assert_lowest_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xp_en[i*N + j] |-> !lower_hit[i][j]);
    end
  end

  assert_reg_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (xp_en_q == $past(xp_en)));
endmodule

bind xbar_prio_top xbar_prio_chk #(.N(N), .W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req        (req),
  .dst_addr   (dst_addr),
  .proc_rdata (proc_rdata),
  .proc_gnt   (proc_gnt),
  .mem_act    (mem_act),
  .xp_en      (xp_en),
  .xp_en_q    (xp_en_q)
);

// File: tb/xbar_prio_top_tb.sv
`timescale 1ns/1ps
module xbar_prio_top_tb;
  localparam int N = 4;
  localparam int W = 8;
  localparam int K = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   req = '0;
  logic [N*K-1:0] dst_addr = '0;
  logic [N*W-1:0] proc_wdata = '0;
  logic [N*W-1:0] mem_rdata = '0;
  logic [N*W-1:0] mem_wdata;
  logic [N-1:0]   mem_act;
  logic [N*W-1:0] proc_rdata;
  logic [N-1:0]   proc_gnt;
  logic [N*N-1:0] xp_en;
  logic [N*N-1:0] xp_en_q;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  xbar_prio_top #(.N(N), .W(W)) u_dut (.*);

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected matrix: a processor wins if no smaller index requests the same target
  function automatic logic [N*N-1:0] model_en(logic [N-1:0] r, logic [N*K-1:0] a);
    logic [N*N-1:0] m = '0;
    for (int i = 0; i < N; i++) begin
      bit beaten = 0;
      for (int p = 0; p < i; p++)
        if (r[p] && a[p*K +: K] == a[i*K +: K]) beaten = 1;
      if (r[i] && !beaten) m[i*N + int'(a[i*K +: K])] = 1'b1;
    end
    return m;
  endfunction

  task automatic run_case(logic [N-1:0] r, logic [N*K-1:0] a, logic [7:0] seed,
                          string name);
    logic [N*N-1:0] exp_en;
    @(negedge clk);
    req = r;
    dst_addr = a;
    for (int i = 0; i < N; i++) begin
      proc_wdata[i*W +: W] = seed + 8'(i * 17);
      mem_rdata[i*W +: W]  = ~seed - 8'(i * 29);
    end
    #1;
    exp_en = model_en(r, a);
    chk(xp_en == exp_en, {name, " R1 R2 R3 xp_en"}, 64'(xp_en), 64'(exp_en));
    for (int j = 0; j < N; j++) begin
      logic [W-1:0] ew = '0;
      bit act = 0;
      for (int i = 0; i < N; i++)
        if (exp_en[i*N + j]) begin ew = proc_wdata[i*W +: W]; act = 1; end
      chk(mem_act[j] == act, {name, " R4 mem_act"}, 64'(mem_act[j]), 64'(act));
      chk(mem_wdata[j*W +: W] == ew, {name, " R5 mem_wdata"},
          64'(mem_wdata[j*W +: W]), 64'(ew));
    end
    for (int i = 0; i < N; i++) begin
      logic [W-1:0] er = '0;
      bit g = 0;
      for (int j = 0; j < N; j++)
        if (exp_en[i*N + j]) begin er = mem_rdata[j*W +: W]; g = 1; end
      chk(proc_gnt[i] == g, {name, " R7 proc_gnt"}, 64'(proc_gnt[i]), 64'(g));
      chk(proc_rdata[i*W +: W] == er, {name, " R6 proc_rdata"},
          64'(proc_rdata[i*W +: W]), 64'(er));
    end
    @(posedge clk);
    #1;
    chk(xp_en_q == exp_en, {name, " R8 xp_en_q"}, 64'(xp_en_q), 64'(exp_en));
  endtask

  task automatic t_reset();
    #1;
    chk(xp_en_q == '0, "reset R8 xp_en_q", 64'(xp_en_q), 64'd0);
    chk(proc_gnt == '0 && mem_act == '0, "reset R7 idle grants",
        64'({proc_gnt, mem_act}), 64'd0);
  endtask

  // Registered copy stays cleared in reset even with live requests
  task automatic t_reset_hold();
    @(negedge clk);
    rst_n = 1'b0;
    req = 4'b1111;
    dst_addr = 8'b11_10_01_00;
    @(posedge clk);
    #1;
    chk(xp_en_q == '0, "reset hold R8 xp_en_q", 64'(xp_en_q), 64'd0);
    chk(xp_en == 16'h8421, "reset hold R8 comb xp_en", 64'(xp_en), 64'h8421);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    run_case(4'b0000, 8'b11_10_01_00, 8'h11, "idle");
    run_case(4'b1111, 8'b00_01_10_11, 8'h22, "disjoint");
    run_case(4'b1111, 8'b10_10_10_10, 8'h33, "all same col");
    run_case(4'b1100, 8'b01_01_00_00, 8'h44, "rows 2,3 contend");
    run_case(4'b1010, 8'b11_00_11_00, 8'h55, "rows 1,3 contend");
    run_case(4'b0001, 8'b00_00_00_11, 8'h66, "idle rows address R2");
    run_case(4'b1110, 8'b01_01_01_00, 8'h77, "three contend");
    run_case(4'b1011, 8'b11_00_11_11, 8'h88, "mixed");
    t_reset_hold();
    run_case(4'b0110, 8'b00_00_00_00, 8'h99, "after reset");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule